// File: doc/BRIEF.md
# PHY Event Interrupt Register

This block is a 16-bit management register for a PHY. It keeps eight event conditions as sticky flags in its low byte and holds eight enable bits in its high byte. Whenever a flag is set and its enable is set, the block raises one level-active interrupt line. The interrupt output comes from a register.

Six of the event inputs are single-cycle pulses from the PHY. These are jabber, page received, parallel-detect fault, link-partner acknowledge, remote fault and auto-negotiation done. The other two inputs are levels, and the block qualifies them by their edges. The receive-error input sets its flag only on a rising edge. The link-status input sets its flag on any change in either direction.

A simple strobed read/write port stands in for serial management access. A read returns the whole word and clears the flags at the next clock edge. A write loads only the enable byte. With every enable at zero, software can poll the flags and no interrupt is raised.

Top module: `phy_irq_reg`

## Requirements
- R1: While reset is asserted and right after it, the register reads 16'h0000 and `irq` is 0.
- R2: A pulse on a pulse-type event input sets its flag in the register on the next clock edge, and the flag stays set until a read. Flag bit positions are: 7 jabber, 6 receive error, 5 page received, 4 parallel-detect fault, 3 link-partner acknowledge, 2 link-status change, 1 remote fault, 0 auto-negotiation done.
- R3: `reg_rdata` always shows {enables, flags}. A cycle with `reg_rd` high returns the values held before the clear, and at the next edge it clears bits 7:0.
- R4: An event that is detected in the same cycle as a clearing read leaves its flag set after that edge.
- R5: The receive-error flag is set only when `rx_err` changes from 0 to 1. Holding `rx_err` high does not set the flag again after a read has cleared it.
- R6: The link-status change flag is set when `link_ok` rises and also when it falls. `link_ok` is compared with its value at the previous edge, and that value is 0 after reset.
- R7: A cycle with `reg_wr` high loads `reg_wdata[15:8]` into enable bits 15:8 at the next edge. Write data bits 7:0 have no effect on the flags. Without a write, the enables keep their value.
- R8: `irq` equals the OR over n of (flag n AND enable n). It changes on the same edge as the flags and enables it depends on.
- R9: With all enables at 0, the flags still record events and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_jabber | input | 1 | Jabber detected pulse |
| rx_err | input | 1 | Receive error level |
| ev_page_rx | input | 1 | Page received pulse |
| ev_pd_fault | input | 1 | Parallel-detect fault pulse |
| ev_lp_ack | input | 1 | Link-partner acknowledge pulse |
| link_ok | input | 1 | Link status level (1 = up) |
| ev_rem_fault | input | 1 | Remote fault pulse |
| ev_an_done | input | 1 | Auto-negotiation done pulse |
| reg_rd | input | 1 | Read strobe; clears flags at the next edge |
| reg_wr | input | 1 | Write strobe; loads the enable byte |
| reg_wdata | input | 16 | Write data (bits 15:8 used) |
| reg_rdata | output | 16 | {enables, flags} |
| irq | output | 1 | Interrupt, level-active |

## Verification
The assertions check these properties on every cycle:
- `irq` agrees with the masked flags that appear on the read port.
- The enable byte stays stable unless there is a write, and it takes the write data when there is one.
- A pulse event or a qualified edge shows up as its flag one edge later.
- A read with no events pending leaves the flags empty.

Only the bench's scenarios show the rest:
- An event that lands on the same edge as a read is not lost.
- Holding `rx_err` high sets its flag only once.
- Polling with every enable at zero records the events and raises no interrupt.
- The register agrees with a reference model over long random sequences of reads and writes.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
    localparam int NUM_EVT = 8;
    localparam int REG_W   = 2 * NUM_EVT;

    // flag bit positions (the enables follow at +NUM_EVT)
    localparam int EV_ANEG  = 0;
    localparam int EV_RFLT  = 1;
    localparam int EV_LINK  = 2;
    localparam int EV_LPACK = 3;
    localparam int EV_PDF   = 4;
    localparam int EV_PAGE  = 5;
    localparam int EV_RXERR = 6;
    localparam int EV_JAB   = 7;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        logic rx_prev;
        logic link_prev;
    } qual_state_t;

    typedef struct packed {
        evt_vec_t flags;
        evt_vec_t enables;
        logic     irq;
    } bank_state_t;
endpackage

// File: rtl/phy_evt_qualify.sv
module phy_evt_qualify
    import phy_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t raw,
    output evt_vec_t hit
);
    qual_state_t st_d, st_q;

    always_comb begin
        st_d.rx_prev   = raw[EV_RXERR];
        st_d.link_prev = raw[EV_LINK];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        if (i == EV_RXERR) begin : g_rise
            assign hit[i] = raw[i] & ~st_q.rx_prev;
        end else if (i == EV_LINK) begin : g_toggle
            assign hit[i] = raw[i] ^ st_q.link_prev;
        end else begin : g_pulse
            assign hit[i] = raw[i];
        end
    end
endmodule

// File: rtl/phy_flag_bank.sv
module phy_flag_bank
    import phy_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  evt_vec_t         hit,
    input  logic             rd_clr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output evt_vec_t         flags,
    output evt_vec_t         enables,
    output logic             irq
);
    bank_state_t st_d, st_q;
    logic        unused_wr_low;

    // low byte of the write word has no storage behind it
    assign unused_wr_low = ^wr_data[NUM_EVT-1:0];

    always_comb begin
        st_d = st_q;
        // clear first, then set: an event on a read edge survives
        if (rd_clr) st_d.flags = '0;
        st_d.flags = st_d.flags | hit;
        if (wr_en) st_d.enables = wr_data[REG_W-1:NUM_EVT];
        st_d.irq = |(st_d.flags & st_d.enables);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags   = st_q.flags;
    assign enables = st_q.enables;
    assign irq     = st_q.irq;
endmodule

// File: rtl/phy_irq_reg.sv
module phy_irq_reg
    import phy_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_jabber,
    input  logic        rx_err,
    input  logic        ev_page_rx,
    input  logic        ev_pd_fault,
    input  logic        ev_lp_ack,
    input  logic        link_ok,
    input  logic        ev_rem_fault,
    input  logic        ev_an_done,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    evt_vec_t raw, hit, flags, enables;

    always_comb begin
        raw           = '0;
        raw[EV_JAB]   = ev_jabber;
        raw[EV_RXERR] = rx_err;
        raw[EV_PAGE]  = ev_page_rx;
        raw[EV_PDF]   = ev_pd_fault;
        raw[EV_LPACK] = ev_lp_ack;
        raw[EV_LINK]  = link_ok;
        raw[EV_RFLT]  = ev_rem_fault;
        raw[EV_ANEG]  = ev_an_done;
    end

    phy_evt_qualify u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw),
        .hit   (hit)
    );

    phy_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .rd_clr  (reg_rd),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .flags   (flags),
        .enables (enables),
        .irq     (irq)
    );

    assign reg_rdata = {enables, flags};
endmodule

// File: rtl/phy_irq_reg_chk.sv
module phy_irq_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_jabber,
    input logic        rx_err,
    input logic        ev_page_rx,
    input logic        ev_pd_fault,
    input logic        ev_lp_ack,
    input logic        link_ok,
    input logic        ev_rem_fault,
    input logic        ev_an_done,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        irq
);
    logic rx_seen_q, link_seen_q;
    logic quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_seen_q   <= 1'b0;
            link_seen_q <= 1'b0;
        end else begin
            rx_seen_q   <= rx_err;
            link_seen_q <= link_ok;
        end
    end

    assign quiet = !ev_jabber && !ev_page_rx && !ev_pd_fault && !ev_lp_ack &&
                   !ev_rem_fault && !ev_an_done &&
                   !(rx_err && !rx_seen_q) && (link_ok == link_seen_q);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(reg_rdata[15:8] & reg_rdata[7:0]));

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata[15:8]));

    // R7
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[15:8] == $past(reg_wdata[15:8]));

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && quiet) |=> reg_rdata[7:0] == 8'h00);

    // R2
    jab_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_jabber |=> reg_rdata[7]);

    // R2
    an_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_an_done |=> reg_rdata[0]);

    // R5
    rxerr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !rx_seen_q) |=> reg_rdata[6]);

    // R6
    link_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok != link_seen_q) |=> reg_rdata[2]);
endmodule

bind phy_irq_reg phy_irq_reg_chk u_chk (.*);

// File: tb/phy_irq_reg_test.sv
`timescale 1ns/1ps
module phy_irq_reg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_jabber = 0, rx_err = 0, ev_page_rx = 0, ev_pd_fault = 0;
    logic ev_lp_ack = 0, link_ok = 0, ev_rem_fault = 0, ev_an_done = 0;
    logic reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_flags = '0, m_en = '0;
    logic m_rx_prev = 0, m_link_prev = 0;

    always #2.5 clk = ~clk;

    phy_irq_reg uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_irq();
        return |(m_flags & m_en);
    endfunction

    function automatic logic [7:0] m_hit(input logic [7:0] pul, input logic rx, input logic lk);
        logic [7:0] h;
        h    = pul & 8'b1011_1011;
        h[6] = rx & ~m_rx_prev;
        h[2] = lk ^ m_link_prev;
        return h;
    endfunction

    // pul bit order: 7 jab, 5 page, 4 pdf, 3 lpack, 1 rflt, 0 aneg
    task automatic step(input logic rd, input logic wr, input logic [15:0] wd,
                        input logic [7:0] pul, input logic rx, input logic lk);
        logic [7:0] nf, ne;
        @(negedge clk);
        check("R3/R8 model", {15'd0, irq, reg_rdata}, {15'd0, m_irq(), m_en, m_flags});
        reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        ev_jabber = pul[7]; ev_page_rx = pul[5]; ev_pd_fault = pul[4];
        ev_lp_ack = pul[3]; ev_rem_fault = pul[1]; ev_an_done = pul[0];
        rx_err = rx; link_ok = lk;
        nf = (rd ? 8'h00 : m_flags) | m_hit(pul, rx, lk);
        ne = wr ? wd[15:8] : m_en;
        @(posedge clk);
        m_flags = nf; m_en = ne; m_rx_prev = rx; m_link_prev = lk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 16'h0, 8'h00, rx_err, link_ok);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {15'd0, irq, reg_rdata}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {15'd0, irq, reg_rdata}, 32'd0);

        // R9: polling with enables at 0
        step(0, 0, 16'h0, 8'b1000_0001, 0, 0);
        @(negedge clk);
        check("R9 flags", {24'd0, reg_rdata[7:0]}, 32'h81);
        check("R9 irq low", {31'd0, irq}, 32'd0);
        // R3: read returns, then clears
        step(1, 0, 16'h0, 8'h00, 0, 0);
        @(negedge clk);
        check("R3 cleared", {24'd0, reg_rdata[7:0]}, 32'h00);

        // R7: write with low byte set, flags untouched
        step(0, 1, 16'hA5FF, 8'h00, 0, 0);
        @(negedge clk);
        check("R7 write", {16'd0, reg_rdata}, 32'hA500);

        // R2 + R8: page received, enabled (bit 13 set in A5)
        step(0, 0, 16'h0, 8'b0010_0000, 0, 0);
        @(negedge clk);
        check("R2 page flag", {24'd0, reg_rdata[7:0]}, 32'h20);
        check("R8 irq high", {31'd0, irq}, 32'd1);

        // R4: event on the read edge survives
        step(1, 0, 16'h0, 8'b0000_1000, 0, 0);
        @(negedge clk);
        check("R4 kept", {24'd0, reg_rdata[7:0]}, 32'h08);
        step(1, 0, 16'h0, 8'h00, 0, 0);

        // R5: rx_err held high sets once
        step(0, 0, 16'h0, 8'h00, 1, 0);
        step(1, 0, 16'h0, 8'h00, 1, 0);
        idle(2);
        @(negedge clk);
        check("R5 held no reset", {24'd0, reg_rdata[7:0]}, 32'h00);
        step(0, 0, 16'h0, 8'h00, 0, 0);
        @(negedge clk);
        check("R5 fall ignored", {24'd0, reg_rdata[7:0]}, 32'h00);

        // R6: link rise and fall
        step(0, 0, 16'h0, 8'h00, 0, 1);
        @(negedge clk);
        check("R6 rise", {24'd0, reg_rdata[7:0]}, 32'h04);
        step(1, 0, 16'h0, 8'h00, 0, 1);
        step(0, 0, 16'h0, 8'h00, 0, 0);
        @(negedge clk);
        check("R6 fall", {24'd0, reg_rdata[7:0]}, 32'h04);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] pul;
            logic rx, lk, rd, wr;
            pul = 8'h00;
            for (int b = 0; b < 8; b++) pul[b] = ($urandom % 10) == 0;
            rx = (($urandom % 6) == 0) ? ~rx_err : rx_err;
            lk = (($urandom % 8) == 0) ? ~link_ok : link_ok;
            rd = ($urandom % 5) == 0;
            wr = ($urandom % 9) == 0;
            step(rd, wr, 16'($urandom), pul, rx, lk);
        end
        @(negedge clk);
        check("R2 final", {15'd0, irq, reg_rdata}, {15'd0, m_irq(), m_en, m_flags});

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule